// File: doc/BRIEF.md
# Pipelined Multi-ID Read Requester

This block is a TileLink-UL client that fetches a run of 32-byte blocks from consecutive pages without waiting for each reply. A single command supplies a base page number, a byte offset inside the page, a block count and an optional write. When the write is requested, one PutFullData goes out first. Then one Get per page is issued back to back on channel A. Each request in flight holds its own source ID, taken from a fixed contiguous range that includes its lower bound and excludes its upper bound.

Responses on channel D may come back in any order. The source field of each beat selects a slot in a small result store, and the host reads the store through a separate select port. An ID stays reserved from the cycle its request is accepted until its response beat is taken. No ID outside the declared range is ever driven. A command that asks for more blocks than there are IDs is clamped to the range size, and a sticky error flag records the overflow. When every reply for the command has arrived, a one-cycle done pulse fires and the block accepts the next command.

Top module: `mor_read_client`

## Requirements
- R1: During and right after reset, cmd_ready is 1 and a_valid, d_ready, done and err_range are all 0.
- R2: Every Get carries a_opcode 4, a_size 5, a_param 0 and an all-ones mask. The k-th Get of a command (k from 0) targets address ((page + k) << 12) + (offset with bits 4..0 cleared).
- R3: The k-th Get uses source SRC_BASE + k (0xA + k by default). The Put uses source SRC_BASE.
- R4: While a_ready stays high, the Gets of one command are offered on consecutive cycles, with no wait for any channel D beat.
- R5: When the write is requested, a PutFullData (a_opcode 0) carrying cmd_wdata goes out before any Get, at the aligned address of the base page. a_valid then stays low until an AccessAck (d_opcode 0) with source SRC_BASE is taken, because the first Get needs that ID.
- R6: While a_valid is high and a_ready is low, a_valid stays high and the whole A payload stays unchanged.
- R7: An ID is never reissued while its reply is outstanding. A command never issues more than SRC_NUM requests.
- R8: A count above SRC_NUM (4 by default) sets err_range, which then holds until reset. Exactly SRC_NUM Gets are issued, with IDs SRC_BASE up to SRC_BASE+SRC_NUM-1.
- R9: An AccessAckData beat (d_opcode 1) stores d_data in slot d_source - SRC_BASE, whatever the order of arrival. res_data shows the slot chosen by res_sel.
- R10: d_ready is 1 while any ID is outstanding and 0 when none is.
- R11: done pulses for exactly one cycle once all Get replies and any Put acknowledge have arrived. cmd_ready is 1 on the following cycle.
- R12: A channel D beat whose source is not an outstanding ID changes no slot and counts toward no completion.
- R13: A command with count 0 and no write produces no channel A traffic, and done pulses on the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and taking a command |
| cmd_page | input | ADDR_W-PAGE_BITS | Base page number |
| cmd_offset | input | PAGE_BITS | Byte offset within the page |
| cmd_count | input | CNT_W | Number of Gets requested |
| cmd_write | input | 1 | Send a Put before the Gets |
| cmd_wdata | input | DATA_W | Put payload |
| a_valid | output | 1 | Channel A valid |
| a_ready | input | 1 | Channel A ready |
| a_opcode | output | 3 | Channel A opcode |
| a_param | output | 3 | Channel A param |
| a_size | output | 3 | Log2 transfer size |
| a_source | output | SRC_W | Channel A source ID |
| a_address | output | ADDR_W | Channel A byte address |
| a_mask | output | DATA_W/8 | Byte lane mask |
| a_data | output | DATA_W | Channel A data |
| d_valid | input | 1 | Channel D valid |
| d_ready | output | 1 | Channel D ready |
| d_opcode | input | 3 | Channel D opcode |
| d_source | input | SRC_W | Channel D source ID |
| d_data | input | DATA_W | Channel D data |
| res_sel | input | IDX_W | Result slot select |
| res_data | output | DATA_W | Selected result slot |
| done | output | 1 | Command complete pulse |
| err_range | output | 1 | Sticky count-over-range flag |

## Verification
A reserved bit that gets stuck set shows up as a_valid staying low for the first Get after a Put, or as done never firing. This becomes visible within a cycle of the beat that should have cleared it. A wrong issue counter shows up at once in a_address or a_source on the next offered Get, and as a count of A handshakes that differs from the clamped request. Slot indexing errors only show up when the host reads res_data after out-of-order replies. Beats carrying a stray source expose a missing reservation check through an early done or a changed slot.

// File: rtl/mor_pkg.sv
package mor_pkg;
  localparam logic [2:0] OP_PUT_FULL = 3'd0;
  localparam logic [2:0] OP_GET      = 3'd4;
  localparam logic [2:0] OP_ACK      = 3'd0;
  localparam logic [2:0] OP_ACK_DATA = 3'd1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUT,
    ST_GET,
    ST_DRAIN
  } mor_state_e;
endpackage

// File: rtl/mor_id_pool.sv
module mor_id_pool #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_v,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic             free_v,
  input  logic [IDX_W-1:0] free_idx,
  output logic [N-1:0]     busy_o
);
  logic [N-1:0] busy_q, busy_d;

  always_comb begin
    busy_d = busy_q;
    if (alloc_v) busy_d[alloc_idx] = 1'b1;
    if (free_v)  busy_d[free_idx]  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= busy_d;
  end

  assign busy_o = busy_q;

  // R7: an ID is only handed out when it is free
  a_r7_no_reuse: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_v |-> !busy_q[alloc_idx]);
  // R12: only reserved IDs are released
  a_r12_free_held: assert property (@(posedge clk) disable iff (!rst_n)
    free_v |-> busy_q[free_idx]);
  // R7: a reserved ID stays reserved in the next cycle
  a_r7_alloc_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_v |=> busy_q[$past(alloc_idx)]);
endmodule

// File: rtl/mor_result_buf.sv
module mor_result_buf #(
  parameter int N      = 4,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_v,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot_q [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_v && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[g] <= '0;
      else if (slot_en) slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/mor_read_client.sv
module mor_read_client
  import mor_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 256,
  parameter int PAGE_BITS = 12,
  parameter int SRC_W     = 4,
  parameter int SRC_BASE  = 10,
  parameter int SRC_NUM   = 4,
  parameter int CNT_W     = 4,
  parameter int LG_SIZE   = 5,
  localparam int PAGE_W   = ADDR_W - PAGE_BITS,
  localparam int IDX_W    = (SRC_NUM > 1) ? $clog2(SRC_NUM) : 1,
  localparam int MASK_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic [PAGE_BITS-1:0] cmd_offset,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              a_valid,
  input  logic              a_ready,
  output logic [2:0]        a_opcode,
  output logic [2:0]        a_param,
  output logic [2:0]        a_size,
  output logic [SRC_W-1:0]  a_source,
  output logic [ADDR_W-1:0] a_address,
  output logic [MASK_W-1:0] a_mask,
  output logic [DATA_W-1:0] a_data,
  input  logic              d_valid,
  output logic              d_ready,
  input  logic [2:0]        d_opcode,
  input  logic [SRC_W-1:0]  d_source,
  input  logic [DATA_W-1:0] d_data,
  input  logic [IDX_W-1:0]  res_sel,
  output logic [DATA_W-1:0] res_data,
  output logic              done,
  output logic              err_range
);
  localparam logic [CNT_W-1:0]     NUM_C   = CNT_W'(SRC_NUM);
  localparam logic [SRC_W-1:0]     NUM_S   = SRC_W'(SRC_NUM);
  localparam logic [SRC_W-1:0]     BASE_C  = SRC_W'(SRC_BASE);
  localparam logic [PAGE_BITS-1:0] OFF_MSK = ~PAGE_BITS'((1 << LG_SIZE) - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  mor_state_e st_q, st_d;
  logic [PAGE_W-1:0]    page_q;
  logic [PAGE_BITS-1:0] off_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [CNT_W-1:0]     eff_q, issued_q, issued_d, got_q, got_d, eff_in;
  logic                 err_q, err_d, load;
  logic [SRC_NUM-1:0]   busy;
  logic                 alloc_v;
  logic [IDX_W-1:0]     alloc_idx, cur_idx;
  logic [SRC_W-1:0]     d_off;
  logic                 d_hit, wr_v, is_put;

  assign eff_in  = (cmd_count > NUM_C) ? NUM_C : cmd_count;
  assign cur_idx = issued_q[IDX_W-1:0];

  // channel D side: a beat counts only when its ID is reserved
  assign d_ready = |busy;
  assign d_off   = d_source - BASE_C;
  assign d_hit   = d_valid && d_ready && (d_source >= BASE_C) && (d_off < NUM_S)
                   && busy[d_off[IDX_W-1:0]];
  assign wr_v    = d_hit && (d_opcode == OP_ACK_DATA);

  always_comb begin
    st_d      = st_q;
    load      = 1'b0;
    cmd_ready = 1'b0;
    a_valid   = 1'b0;
    alloc_v   = 1'b0;
    alloc_idx = cur_idx;
    issued_d  = issued_q;
    done      = 1'b0;
    case (st_q)
      ST_IDLE: begin
        cmd_ready = 1'b1;
        if (cmd_valid) begin
          load     = 1'b1;
          issued_d = '0;
          if (cmd_write)          st_d = ST_PUT;
          else if (eff_in == '0)  st_d = ST_DRAIN;
          else                    st_d = ST_GET;
        end
      end
      ST_PUT: begin
        a_valid   = 1'b1;
        alloc_idx = '0;
        if (a_ready) begin
          alloc_v = 1'b1;
          st_d    = (eff_q == '0) ? ST_DRAIN : ST_GET;
        end
      end
      ST_GET: begin
        a_valid = !busy[cur_idx];
        if (a_valid && a_ready) begin
          alloc_v  = 1'b1;
          issued_d = issued_q + 1'b1;
          if (issued_d == eff_q) st_d = ST_DRAIN;
        end
      end
      default: begin
        if ((got_q == eff_q) && (busy == '0)) begin
          done = 1'b1;
          st_d = ST_IDLE;
        end
      end
    endcase
  end

  assign got_d = load ? '0 : got_q + CNT_W'(wr_v);
  assign err_d = err_q | (load && (cmd_count > NUM_C));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q     <= ST_IDLE;
      issued_q <= '0;
      got_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      issued_q <= issued_d;
      got_q    <= got_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      page_q  <= '0;
      off_q   <= '0;
      eff_q   <= '0;
      wdata_q <= '0;
    end else if (load) begin
      page_q  <= cmd_page;
      off_q   <= cmd_offset & OFF_MSK;
      eff_q   <= eff_in;
      wdata_q <= cmd_wdata;
    end
  end

  // channel A payload, held by registers that move only on a handshake
  assign is_put    = (st_q == ST_PUT);
  assign a_opcode  = is_put ? OP_PUT_FULL : OP_GET;
  assign a_param   = 3'd0;
  assign a_size    = 3'(LG_SIZE);
  assign a_mask    = '1;
  assign a_data    = is_put ? wdata_q : '0;
  assign a_source  = is_put ? BASE_C : BASE_C + SRC_W'(cur_idx);
  assign a_address = is_put ? {page_q, off_q}
                            : {page_q + PAGE_W'(issued_q), off_q};
  assign err_range = err_q;

  mor_id_pool #(.N(SRC_NUM), .IDX_W(IDX_W)) u_pool (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .alloc_v  (alloc_v),
    .alloc_idx(alloc_idx),
    .free_v   (d_hit),
    .free_idx (d_off[IDX_W-1:0]),
    .busy_o   (busy)
  );

  mor_result_buf #(.N(SRC_NUM), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_buf (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_v   (wr_v),
    .wr_idx (d_off[IDX_W-1:0]),
    .wr_data(d_data),
    .rd_idx (res_sel),
    .rd_data(res_data)
  );

  // R2: Get shape and alignment seen at the port
  a_r2_get_shape: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (a_valid && a_opcode == OP_GET) |-> (a_size == 3'(LG_SIZE))
      && (a_address[LG_SIZE-1:0] == '0));
  // R6: payload held under backpressure
  a_r6_hold_payload: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (a_valid && !a_ready) |=> a_valid && $stable(a_address) && $stable(a_source)
      && $stable(a_opcode) && $stable(a_data));
  // R7: no ID outside the declared range
  a_r7_src_in_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    a_valid |-> (a_source >= BASE_C) && ((a_source - BASE_C) < NUM_S));
  // R8: overflow flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_range |=> err_range);
  // R11: done is a single-cycle pulse followed by readiness
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done && cmd_ready);
  // R10: nothing in flight means no outstanding reservations when idle
  a_r10_idle_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_ready |-> !d_ready);
endmodule

// File: tb/mor_read_client_test.sv
module mor_read_client_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid, cmd_ready, cmd_write;
  logic [19:0]  cmd_page;
  logic [11:0]  cmd_offset;
  logic [3:0]   cmd_count;
  logic [255:0] cmd_wdata;
  logic         a_valid, a_ready;
  logic [2:0]   a_opcode, a_param, a_size;
  logic [3:0]   a_source;
  logic [31:0]  a_address;
  logic [31:0]  a_mask;
  logic [255:0] a_data;
  logic         d_valid, d_ready;
  logic [2:0]   d_opcode;
  logic [3:0]   d_source;
  logic [255:0] d_data;
  logic [1:0]   res_sel;
  logic [255:0] res_data;
  logic         done, err_range;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mor_read_client uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_page(cmd_page),
    .cmd_offset(cmd_offset), .cmd_count(cmd_count), .cmd_write(cmd_write),
    .cmd_wdata(cmd_wdata),
    .a_valid(a_valid), .a_ready(a_ready), .a_opcode(a_opcode), .a_param(a_param),
    .a_size(a_size), .a_source(a_source), .a_address(a_address), .a_mask(a_mask),
    .a_data(a_data),
    .d_valid(d_valid), .d_ready(d_ready), .d_opcode(d_opcode), .d_source(d_source),
    .d_data(d_data),
    .res_sel(res_sel), .res_data(res_data), .done(done), .err_range(err_range)
  );

  function automatic logic [255:0] pat(input logic [31:0] k);
    return {8{32'hD0D0_0000 + k}};
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send_cmd(input logic [19:0] pg, input logic [11:0] off,
                          input logic [3:0] cnt, input logic wr, input logic [255:0] wd);
    cmd_valid = 1'b1; cmd_page = pg; cmd_offset = off;
    cmd_count = cnt; cmd_write = wr; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic respond(input logic [3:0] src, input logic [2:0] op, input logic [255:0] dat);
    d_valid = 1'b1; d_source = src; d_opcode = op; d_data = dat;
    @(negedge clk);
    d_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 cmd_ready", 256'(cmd_ready), 256'(1));
    chk("R1 a_valid",   256'(a_valid),   256'(0));
    chk("R1 d_ready",   256'(d_ready),   256'(0));
    chk("R1 done",      256'(done),      256'(0));
    chk("R1 err_range", 256'(err_range), 256'(0));
  endtask

  task automatic t_burst;
    a_ready = 1'b1;
    send_cmd(20'h80022, 12'h388, 4'd3, 1'b0, '0);
    for (int k = 0; k < 3; k++) begin
      chk("R4 back-to-back valid", 256'(a_valid), 256'(1));
      chk("R2 address", 256'(a_address), 256'(((32'h80022 + k) << 12) + 32'h380));
      chk("R3 source", 256'(a_source), 256'(4'hA + k));
      chk("R2 opcode/size/param", 256'({a_opcode, a_size, a_param}), 256'({3'd4, 3'd5, 3'd0}));
      chk("R2 mask", 256'(a_mask), 256'(32'hFFFF_FFFF));
      @(negedge clk);
    end
    chk("R4 burst ends", 256'(a_valid), 256'(0));
    chk("R10 d_ready outstanding", 256'(d_ready), 256'(1));
    respond(4'hC, 3'd1, pat(2));
    respond(4'hA, 3'd1, pat(0));
    chk("R11 no early done", 256'(done), 256'(0));
    respond(4'hB, 3'd1, pat(1));
    chk("R11 done pulse", 256'(done), 256'(1));
    @(negedge clk);
    chk("R11 done single", 256'(done), 256'(0));
    chk("R11 ready again", 256'(cmd_ready), 256'(1));
    chk("R10 d_ready idle", 256'(d_ready), 256'(0));
    for (int s = 0; s < 3; s++) begin
      res_sel = 2'(s);
      #1;
      chk("R9 out-of-order slot", res_data, pat(s));
    end
  endtask

  task automatic t_put;
    logic [255:0] wd;
    wd = {8{32'h5555_0000}};
    a_ready = 1'b1;
    send_cmd(20'h00100, 12'h05F, 4'd2, 1'b1, wd);
    chk("R5 put first", 256'({a_valid, a_opcode}), 256'({1'b1, 3'd0}));
    chk("R3 put source", 256'(a_source), 256'(4'hA));
    chk("R5 put address", 256'(a_address), 256'(32'h0010_0040));
    chk("R5 put data", a_data, wd);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk("R5 stall on put id", 256'(a_valid), 256'(0));
      @(negedge clk);
    end
    respond(4'hA, 3'd0, '0);
    chk("R5 get after ack", 256'({a_valid, a_opcode, a_source}), 256'({1'b1, 3'd4, 4'hA}));
    chk("R2 get0 address", 256'(a_address), 256'(32'h0010_0040));
    @(negedge clk);
    chk("R2 get1 address", 256'(a_address), 256'(32'h0010_1040));
    chk("R3 get1 source", 256'(a_source), 256'(4'hB));
    @(negedge clk);
    chk("R7 no third get", 256'(a_valid), 256'(0));
    respond(4'hB, 3'd1, pat(11));
    respond(4'hA, 3'd1, pat(10));
    chk("R11 done after put", 256'(done), 256'(1));
    @(negedge clk);
    res_sel = 2'd1;
    #1;
    chk("R9 slot1", res_data, pat(11));
  endtask

  task automatic t_backpressure;
    logic [31:0] addr0;
    logic [3:0]  src0;
    a_ready = 1'b0;
    send_cmd(20'h00020, 12'h000, 4'd1, 1'b0, '0);
    addr0 = a_address; src0 = a_source;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 valid held", 256'(a_valid), 256'(1));
      chk("R6 payload held", 256'({a_address, a_source}), 256'({addr0, src0}));
    end
    chk("R2 held address", 256'(addr0), 256'(32'h0002_0000));
    a_ready = 1'b1;
    @(negedge clk);
    a_ready = 1'b0;
    chk("R6 released", 256'(a_valid), 256'(0));
    respond(4'hA, 3'd1, pat(20));
    chk("R11 done bp", 256'(done), 256'(1));
    @(negedge clk);
  endtask

  task automatic t_overflow;
    int seen;
    seen = 0;
    a_ready = 1'b1;
    send_cmd(20'h00300, 12'h000, 4'd6, 1'b0, '0);
    chk("R8 err set", 256'(err_range), 256'(1));
    for (int i = 0; i < 8; i++) begin
      if (a_valid) begin
        chk("R8 clamped source", 256'(a_source), 256'(4'hA + seen));
        seen++;
      end
      @(negedge clk);
    end
    chk("R8 clamped count", 256'(seen), 256'(4));
    for (int s = 3; s >= 0; s--) respond(4'(4'hA + s), 3'd1, pat(32'h40 + s));
    chk("R11 done overflow", 256'(done), 256'(1));
    @(negedge clk);
    chk("R8 err sticky", 256'(err_range), 256'(1));
    res_sel = 2'd3;
    #1;
    chk("R9 slot3", res_data, pat(32'h43));
  endtask

  task automatic t_stray;
    a_ready = 1'b1;
    send_cmd(20'h00400, 12'h000, 4'd1, 1'b0, '0);
    @(negedge clk);
    respond(4'h3, 3'd1, pat(99));
    chk("R12 out-of-range ignored", 256'({done, d_ready}), 256'({1'b0, 1'b1}));
    respond(4'hB, 3'd1, pat(98));
    chk("R12 idle id ignored", 256'({done, d_ready}), 256'({1'b0, 1'b1}));
    res_sel = 2'd1;
    #1;
    chk("R12 slot untouched", res_data, pat(32'h41));
    respond(4'hA, 3'd1, pat(50));
    chk("R11 done stray", 256'(done), 256'(1));
    res_sel = 2'd0;
    #1;
    chk("R9 slot0 stray", res_data, pat(50));
    @(negedge clk);
  endtask

  task automatic t_zero;
    send_cmd(20'h00500, 12'h000, 4'd0, 1'b0, '0);
    chk("R13 done at once", 256'({done, a_valid}), 256'({1'b1, 1'b0}));
    @(negedge clk);
    chk("R13 ready again", 256'({cmd_ready, a_valid}), 256'({1'b1, 1'b0}));
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_page = '0; cmd_offset = '0;
    cmd_count = '0; cmd_write = 1'b0; cmd_wdata = '0; a_ready = 1'b0;
    d_valid = 1'b0; d_opcode = '0; d_source = '0; d_data = '0; res_sel = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_burst;
    t_put;
    t_backpressure;
    t_zero;
    t_overflow;
    t_stray;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule